// File: doc/BRIEF.md
# Stuff Code Conflict Detector

This block watches the sync maintenance logic of a bit-stuffed TDM demultiplexer. In every minor frame the overhead may carry at most one stuff command, either positive or negative. Upstream decoders send a one-cycle pulse each time they recognise one of the two codes. The block keeps a record of which codes have appeared since the last minor-frame boundary. If a frame closes having carried both codes, the block raises a conflict error and holds it for the whole of the following frame, so that a slow display card can capture it.

A second check compares two independent sync indicators. One is the demultiplexer's own frame-sync flag. The other is the verdict of the parallel sync control. An error is raised whenever the demultiplexer claims sync and the parallel control does not agree. The two errors are merged into a single active-low diagnostic line. Each error is also available separately, also active-low. While frame sync is absent, the stuff check is held off, because stuff codes decoded out of alignment mean nothing.

Top module: `stuff_conflict_mon`

## Requirements
- R1: A synchronous active-high reset drives `err_n`, `conflict_err_n` and `sync_err_n` high from the first clock edge on which `rst` is sampled high, and clears both per-frame stuff records.
- R2: If `pos_hit` and `neg_hit` have each been sampled high at least once during a minor frame while `dmx_sync` is high, then `conflict_err_n` goes low after the clock edge on which the closing `frame_strobe` is sampled. This holds whether the two hits fall on the same cycle or on different cycles.
- R3: A frame that contains only one kind of stuff hit, repeated any number of times, leaves `conflict_err_n` high after its closing strobe.
- R4: A `frame_strobe` empties both records. A positive hit in one frame and a negative hit in the next frame therefore raise no conflict.
- R5: The conflict level set at a strobe edge is held unchanged until the edge of the next strobe. That next edge then loads the result of the frame that has just closed.
- R6: Hits sampled on the same cycle as `frame_strobe` count toward the frame that the strobe closes, not toward the frame that it opens.
- R7: While `dmx_sync` is low, hits are not recorded and the records are emptied. A strobe sampled with `dmx_sync` low loads no conflict.
- R8: `sync_err_n` is low after every clock edge that samples `dmx_sync`=1 and `par_sync`=0. It is high after every other edge. It is re-evaluated on every clock and is never latched.
- R9: `err_n` is low exactly when `conflict_err_n` or `sync_err_n` is low, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_strobe | input | 1 | One-cycle minor-frame boundary pulse |
| pos_hit | input | 1 | Positive stuff command code recognised this cycle |
| neg_hit | input | 1 | Negative stuff command code recognised this cycle |
| dmx_sync | input | 1 | Demultiplexer reports frame sync |
| par_sync | input | 1 | Parallel sync control reports sync |
| err_n | output | 1 | Merged diagnostic error, active low |
| conflict_err_n | output | 1 | Stuff conflict error, active low, held for one frame |
| sync_err_n | output | 1 | Sync disagreement error, active low, unlatched |

## Verification
A held stuff conflict and a fresh sync disagreement can both be present on the merged line in the same cycle. To provoke this, the bench closes a frame that carries both codes. It then lowers `par_sync` during the hold frame that follows. The scoreboard expects both separate lines low and `err_n` low. It then expects `err_n` to stay low on the conflict alone after `par_sync` comes back. A hit that lands on the strobe cycle is a second overlap, between the closing of one frame and the opening of the next. The bench places a negative hit there and expects it to complete the closing frame's conflict and to leave the new frame's record empty.

// File: rtl/scd_pkg.sv
package scd_pkg;

    // Number of error sources merged onto the diagnostic line.
    localparam int unsigned NUM_ERR_SRC = 2;
    localparam int unsigned SRC_CONFLICT = 0;
    localparam int unsigned SRC_SYNC     = 1;

    // Record of stuff command kinds seen in the current minor frame.
    typedef struct packed {
        logic pos;
        logic neg;
    } stuff_rec_t;

    localparam stuff_rec_t REC_EMPTY = '{pos: 1'b0, neg: 1'b0};

    // Combine the stored record with the hits of the present cycle.
    function automatic stuff_rec_t rec_merge(input stuff_rec_t a, input stuff_rec_t b);
        stuff_rec_t r;
        r.pos = a.pos | b.pos;
        r.neg = a.neg | b.neg;
        return r;
    endfunction

    // A frame is in conflict when both command kinds were present.
    function automatic logic rec_conflict(input stuff_rec_t r);
        return r.pos & r.neg;
    endfunction

endpackage

// File: rtl/scd_frame_tracker.sv
module scd_frame_tracker
    import scd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_strobe,
    input  logic sync_ok,
    input  logic pos_hit,
    input  logic neg_hit,
    output logic conflict
);

    stuff_rec_t rec_q;
    stuff_rec_t cur_hits;
    stuff_rec_t closing;

    always_comb begin
        cur_hits.pos = pos_hit;
        cur_hits.neg = neg_hit;
        // Hits on the boundary cycle belong to the frame being closed.
        closing = rec_merge(rec_q, cur_hits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q    <= REC_EMPTY;
            conflict <= 1'b0;
        end else if (frame_strobe) begin
            conflict <= sync_ok & rec_conflict(closing);
            rec_q    <= REC_EMPTY;
        end else if (!sync_ok) begin
            rec_q    <= REC_EMPTY;
        end else begin
            rec_q    <= closing;
        end
    end

endmodule

// File: rtl/scd_sync_check.sv
module scd_sync_check (
    input  logic clk,
    input  logic rst,
    input  logic dmx_sync,
    input  logic par_sync,
    output logic mismatch
);

    // Re-evaluated every cycle; no hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            mismatch <= 1'b0;
        end else begin
            mismatch <= dmx_sync & ~par_sync;
        end
    end

endmodule

// File: rtl/scd_err_merge.sv
module scd_err_merge #(
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0] src_err,
    output logic [N_SRC-1:0] src_err_n,
    output logic             any_err_n
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_inv
        assign src_err_n[i] = ~src_err[i];
    end

    assign any_err_n = ~(|src_err);

endmodule

// File: rtl/stuff_conflict_mon.sv
module stuff_conflict_mon
    import scd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_strobe,
    input  logic pos_hit,
    input  logic neg_hit,
    input  logic dmx_sync,
    input  logic par_sync,
    output logic err_n,
    output logic conflict_err_n,
    output logic sync_err_n
);

    logic                   conflict;
    logic                   mismatch;
    logic [NUM_ERR_SRC-1:0] err_vec;
    logic [NUM_ERR_SRC-1:0] err_vec_n;

    scd_frame_tracker u_track (
        .clk          (clk),
        .rst          (rst),
        .frame_strobe (frame_strobe),
        .sync_ok      (dmx_sync),
        .pos_hit      (pos_hit),
        .neg_hit      (neg_hit),
        .conflict     (conflict)
    );

    scd_sync_check u_sync (
        .clk      (clk),
        .rst      (rst),
        .dmx_sync (dmx_sync),
        .par_sync (par_sync),
        .mismatch (mismatch)
    );

    always_comb begin
        err_vec               = '0;
        err_vec[SRC_CONFLICT] = conflict;
        err_vec[SRC_SYNC]     = mismatch;
    end

    scd_err_merge #(.N_SRC(NUM_ERR_SRC)) u_merge (
        .src_err   (err_vec),
        .src_err_n (err_vec_n),
        .any_err_n (err_n)
    );

    assign conflict_err_n = err_vec_n[SRC_CONFLICT];
    assign sync_err_n     = err_vec_n[SRC_SYNC];

endmodule

// File: rtl/scd_checker.sv
module scd_checker (
    input logic clk,
    input logic rst,
    input logic frame_strobe,
    input logic dmx_sync,
    input logic par_sync,
    input logic err_n,
    input logic conflict_err_n,
    input logic sync_err_n
);

    // R8: disagreement shows on the next cycle
    p_mismatch_low_r8: assert property (@(posedge clk) disable iff (rst)
        (dmx_sync && !par_sync) |=> !sync_err_n);

    // R8: not latched, releases as soon as indicators agree
    p_agree_high_r8: assert property (@(posedge clk) disable iff (rst)
        !(dmx_sync && !par_sync) |=> sync_err_n);

    // R5: conflict level only moves on a strobe edge
    p_hold_frame_r5: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> $stable(conflict_err_n));

    // R7: strobe without frame sync loads no conflict
    p_nosync_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && !dmx_sync) |=> conflict_err_n);

    // R9: a sync disagreement reaches the merged line
    p_merge_sync_r9: assert property (@(posedge clk) disable iff (rst)
        (dmx_sync && !par_sync) |=> !err_n);

endmodule

bind stuff_conflict_mon scd_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_strobe   (frame_strobe),
    .dmx_sync       (dmx_sync),
    .par_sync       (par_sync),
    .err_n          (err_n),
    .conflict_err_n (conflict_err_n),
    .sync_err_n     (sync_err_n)
);

// File: tb/sim_stuff_conflict_mon.sv
module sim_stuff_conflict_mon;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_strobe = 1'b0;
    logic pos_hit = 1'b0;
    logic neg_hit = 1'b0;
    logic dmx_sync = 1'b0;
    logic par_sync = 1'b0;
    logic err_n;
    logic conflict_err_n;
    logic sync_err_n;

    always #10 clk = ~clk;

    stuff_conflict_mon u0 (
        .clk            (clk),
        .rst            (rst),
        .frame_strobe   (frame_strobe),
        .pos_hit        (pos_hit),
        .neg_hit        (neg_hit),
        .dmx_sync       (dmx_sync),
        .par_sync       (par_sync),
        .err_n          (err_n),
        .conflict_err_n (conflict_err_n),
        .sync_err_n     (sync_err_n)
    );

    typedef struct {
        logic  conf_n;
        logic  sync_n;
        logic  all_n;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Expectation state built from the requirements.
    logic m_pos = 1'b0, m_neg = 1'b0, m_conf = 1'b0, m_sync = 1'b0;

    task automatic push_exp(input string tag);
        exp_t e;
        e.conf_n = ~m_conf;
        e.sync_n = ~m_sync;
        e.all_n  = ~(m_conf | m_sync);
        e.tag    = tag;
        q.push_back(e);
    endtask

    task automatic rst_step(input string tag);
        @(negedge clk);
        rst = 1'b1; frame_strobe = 1'b0; pos_hit = 1'b0; neg_hit = 1'b0;
        m_pos = 1'b0; m_neg = 1'b0; m_conf = 1'b0; m_sync = 1'b0;
        push_exp(tag);
    endtask

    task automatic step(input logic st, input logic p, input logic n,
                        input logic ds, input logic ps, input string tag);
        @(negedge clk);
        rst = 1'b0; frame_strobe = st; pos_hit = p; neg_hit = n;
        dmx_sync = ds; par_sync = ps;
        m_sync = ds & ~ps;                       // R8
        if (st) begin                            // R2 R5 R6 R7
            m_conf = ds & (m_pos | p) & (m_neg | n);
            m_pos = 1'b0; m_neg = 1'b0;          // R4
        end else if (!ds) begin                  // R7
            m_pos = 1'b0; m_neg = 1'b0;
        end else begin
            m_pos = m_pos | p; m_neg = m_neg | n;
        end
        push_exp(tag);
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, tag);
    endtask

    // Monitor: pops one expectation per edge, after the outputs settle.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (conflict_err_n !== e.conf_n || sync_err_n !== e.sync_n || err_n !== e.all_n) begin
                    n_fail++;
                    $display("FAIL %s: actual conf_n=%b sync_n=%b err_n=%b expected conf_n=%b sync_n=%b err_n=%b",
                             e.tag, conflict_err_n, sync_err_n, err_n, e.conf_n, e.sync_n, e.all_n);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_step("R1 reset"); rst_step("R1 reset"); rst_step("R1 reset");
        // Open first frame with sync agreed.
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3 open");
        idle(2, "R3 idle");
        // R2: both codes on different cycles
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R2 pos");
        idle(2, "R2 gap");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R2 neg");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 close");
        // R5: held for the whole next frame; R9 overlap with sync disagreement
        idle(2, "R5 hold");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 overlap");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 overlap");
        idle(2, "R9 conflict only");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5 release");
        idle(1, "R5 clear");
        // R3: repeated positive only
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3 pos");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3 pos");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R3 pos");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3 close");
        idle(1, "R3 after");
        // R4: pos in one frame, neg in the next
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 pos");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 close");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4 neg");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4 close");
        idle(1, "R4 after");
        // R2: both on the same cycle
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R2 same cycle");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 close");
        idle(1, "R5 hold");
        // R6: neg lands on the strobe cycle and completes the closing frame
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 pos");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R6 strobe neg");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 new frame pos");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 new frame clean");
        idle(1, "R6 after");
        // R7: no sync, hits ignored; strobe without sync loads nothing
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 nosync hits");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 nosync strobe");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 pos");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 sync drop");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7 neg");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 close clean");
        // R8: disagreement only when dmx_sync=1 and par_sync=0
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 ds0 ps1");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 ds1 ps0");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 release");
        // R1: reset while both errors active
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1 prep");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 prep");
        rst_step("R1 mid reset");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R1 records cleared");
        idle(2, "R1 after");
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule